// File: doc/BRIEF.md
# Audio Master and Bit Clock Divider

This block derives two audio clocks from one fixed module clock: a master clock for an external converter and a serial bit clock for a frame serializer. Neither divider takes a raw divisor. Each takes a small code, and a ratio table turns that code into a ratio. Every ratio of two or more gives a square wave with 50% duty cycle. A ratio of one hands the module clock straight through.

Two code maps are supported. The standard map uses 4-bit codes for both dividers, and both dividers count module clocks. The legacy map uses a shorter table for the master clock and a separate 3-bit table for the bit clock. In the legacy map the bit clock counts master-clock periods, not module clocks. A code with no entry in the selected table raises a flag and parks the affected output low. A code change never cuts a period short: it is adopted only where the output would rise anyway. For a 24.576 MHz module clock and 48 kHz stereo frames of 2 × 32 bits, the standard map needs a bit clock ratio of 8.

Top module: `aud_clk_div`

## Requirements
- R1: With `legacy_map` = 0, `mclk_code` values 1 to 15 select master clock periods of 1, 2, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128, 176 and 192 module clocks.
- R2: With `legacy_map` = 0, `bclk_code` uses the same table as R1. The bit clock counts module clocks, so its period does not depend on `mclk_code`.
- R3: With `legacy_map` = 0, code 0 on either divider is illegal. `code_bad` reads 1 from the first clock edge after the illegal code is applied. The affected output stays low from its next period boundary onward. `code_bad` returns to 0 once both codes are legal again.
- R4: With `legacy_map` = 1, `mclk_code` values 0 to 7 select periods of 1, 2, 4, 6, 8, 12, 16 and 24. Values 8 to 15 are illegal and are handled as described in R3.
- R5: With `legacy_map` = 1, only `bclk_code[2:0]` is decoded and bit 3 is ignored. Values 0 to 5 select 2, 4, 6, 8, 12 and 16 master clock periods, so the bit clock period is the product of the two ratios in module clocks. Values 6 and 7 are illegal.
- R6: For every ratio N of 2 or more, the output is high for the first N/2 module clocks of each period and low for the remaining N/2.
- R7: A ratio of 1 passes the module clock level straight to the output.
- R8: A new code takes effect only at the next rising edge of the divided output. The period already in progress completes at the old ratio.
- R9: `mclk_oe` = 0 holds `mclk_out` low and leaves the bit clock running.
- R10: `bclk_stb` is high for exactly one module clock in each bit clock period. That cycle is the first high cycle of `bclk_out`.
- R11: While `rst` is high, `mclk_out`, `bclk_out`, `bclk_stb` and `code_bad` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock; source of both divided clocks |
| rst | input | 1 | Synchronous active-high reset |
| mclk_code | input | 4 | Master clock divider code |
| bclk_code | input | 4 | Bit clock divider code (only the low 3 bits are used in the legacy map) |
| mclk_oe | input | 1 | Master clock output enable |
| legacy_map | input | 1 | 1 selects the legacy code tables and bit clock parentage |
| mclk_out | output | 1 | Master clock output |
| bclk_out | output | 1 | Bit clock output |
| bclk_stb | output | 1 | One-cycle strobe at the start of each bit clock period |
| code_bad | output | 1 | Set while either divider code is unmapped |

## Verification
The assertions assume that `legacy_map` is held for at least one cycle around any bit clock strobe. The bit clock parentage check reads the map select from the previous cycle. They also assume that codes are synchronous to the module clock. The stimulus respects both assumptions. It changes codes and the map select only at falling edges of the module clock. It then holds each setting for several full output periods before it measures anything. The R8 check is the one exception: there a code is changed deliberately just after a rising output edge.

// File: rtl/aud_clk_pkg.sv
package aud_clk_pkg;

    localparam int RATIO_W  = 8;
    localparam int CODE_W   = 4;
    localparam int LEG_B_W  = 3;

    typedef struct packed {
        logic               valid;
        logic [RATIO_W-1:0] ratio;
    } div_sel_t;

    localparam div_sel_t SEL_NONE = '{valid: 1'b0, ratio: '0};

    function automatic div_sel_t mk_sel(input int unsigned r);
        div_sel_t s;
        s.valid = 1'b1;
        s.ratio = RATIO_W'(r);
        return s;
    endfunction

    // standard map: shared by both dividers, code 0 illegal
    function automatic div_sel_t std_map(input logic [CODE_W-1:0] c);
        case (c)
            4'd1:    return mk_sel(1);
            4'd2:    return mk_sel(2);
            4'd3:    return mk_sel(4);
            4'd4:    return mk_sel(6);
            4'd5:    return mk_sel(8);
            4'd6:    return mk_sel(12);
            4'd7:    return mk_sel(16);
            4'd8:    return mk_sel(24);
            4'd9:    return mk_sel(32);
            4'd10:   return mk_sel(48);
            4'd11:   return mk_sel(64);
            4'd12:   return mk_sel(96);
            4'd13:   return mk_sel(128);
            4'd14:   return mk_sel(176);
            4'd15:   return mk_sel(192);
            default: return SEL_NONE;
        endcase
    endfunction

    // legacy master clock map: codes 0..7
    function automatic div_sel_t leg_m_map(input logic [CODE_W-1:0] c);
        case (c)
            4'd0:    return mk_sel(1);
            4'd1:    return mk_sel(2);
            4'd2:    return mk_sel(4);
            4'd3:    return mk_sel(6);
            4'd4:    return mk_sel(8);
            4'd5:    return mk_sel(12);
            4'd6:    return mk_sel(16);
            4'd7:    return mk_sel(24);
            default: return SEL_NONE;
        endcase
    endfunction

    // legacy bit clock map: 3-bit codes 0..5
    function automatic div_sel_t leg_b_map(input logic [LEG_B_W-1:0] c);
        case (c)
            3'd0:    return mk_sel(2);
            3'd1:    return mk_sel(4);
            3'd2:    return mk_sel(6);
            3'd3:    return mk_sel(8);
            3'd4:    return mk_sel(12);
            3'd5:    return mk_sel(16);
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/aud_code_map.sv
module aud_code_map
    import aud_clk_pkg::*;
(
    input  logic              legacy,
    input  logic [CODE_W-1:0] m_code,
    input  logic [CODE_W-1:0] b_code,
    output div_sel_t          m_sel,
    output div_sel_t          b_sel
);

    always_comb begin
        if (legacy) begin
            m_sel = leg_m_map(m_code);
            b_sel = leg_b_map(b_code[LEG_B_W-1:0]);
        end else begin
            m_sel = std_map(m_code);
            b_sel = std_map(b_code);
        end
    end

endmodule

// File: rtl/aud_div_core.sv
module aud_div_core
    import aud_clk_pkg::*;
#(
    parameter int CNT_W = RATIO_W
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     adv,
    input  div_sel_t req,
    output logic     tick_o,
    output logic     stb_o,
    output logic     lvl_o,
    output logic     out_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    div_sel_t          act_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              lvl_q;
    logic              stb_q;

    logic [CNT_W-1:0]  ratio_c;
    logic [CNT_W-1:0]  half_c;
    logic [CNT_W-1:0]  cnt_nx;
    logic              at_bnd;
    logic              bypass;

    always_comb begin
        ratio_c = CNT_W'(act_q.ratio);
        half_c  = ratio_c >> 1;
        cnt_nx  = cnt_q + CNT_ONE;
        at_bnd  = !act_q.valid || (ratio_c <= CNT_ONE) ||
                  (cnt_q == ratio_c - CNT_ONE);
        bypass  = act_q.valid && (ratio_c == CNT_ONE);
    end

    // new ratio adopted only at a period boundary (the next rising edge)
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= SEL_NONE;
            cnt_q <= '0;
            lvl_q <= 1'b0;
            stb_q <= 1'b0;
        end else begin
            stb_q <= 1'b0;
            if (adv) begin
                if (at_bnd) begin
                    act_q <= req;
                    cnt_q <= '0;
                    lvl_q <= req.valid;
                    stb_q <= req.valid;
                end else begin
                    cnt_q <= cnt_nx;
                    lvl_q <= (cnt_nx < half_c);
                end
            end
        end
    end

    assign tick_o = adv && at_bnd && req.valid;
    assign stb_o  = stb_q;
    assign lvl_o  = lvl_q;
    assign out_o  = bypass ? clk : lvl_q;

    // ---------------- assertions ----------------
    logic live_q;
    logic bnd_prev_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            live_q     <= 1'b0;
            bnd_prev_q <= 1'b0;
        end else begin
            live_q     <= 1'b1;
            bnd_prev_q <= adv && at_bnd;
        end
    end

    assert_ratio_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (live_q && !bnd_prev_q) |-> $stable(act_q))
        else $error("ratio changed away from a period boundary");

    assert_rise_at_start_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(lvl_q) |-> (cnt_q == '0))
        else $error("divided output rose mid-period");

    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (rst)
        (act_q.valid && ratio_c > CNT_ONE) |-> (cnt_q < ratio_c))
        else $error("period counter out of range");

    assert_bad_low_R3: assert property (@(posedge clk) disable iff (rst)
        (live_q && !act_q.valid) |-> !lvl_q)
        else $error("output high with an unmapped ratio");

endmodule

// File: rtl/aud_clk_div.sv
module aud_clk_div
    import aud_clk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] mclk_code,
    input  logic [CODE_W-1:0] bclk_code,
    input  logic              mclk_oe,
    input  logic              legacy_map,
    output logic              mclk_out,
    output logic              bclk_out,
    output logic              bclk_stb,
    output logic              code_bad
);

    div_sel_t m_sel;
    div_sel_t b_sel;
    logic     m_tick, m_stb, m_lvl, m_out;
    logic     b_tick, b_lvl;
    logic     b_adv;
    logic     bad_q;

    aud_code_map u_map (
        .legacy (legacy_map),
        .m_code (mclk_code),
        .b_code (bclk_code),
        .m_sel  (m_sel),
        .b_sel  (b_sel)
    );

    aud_div_core #(.CNT_W(RATIO_W)) u_mdiv (
        .clk    (clk),
        .rst    (rst),
        .adv    (1'b1),
        .req    (m_sel),
        .tick_o (m_tick),
        .stb_o  (m_stb),
        .lvl_o  (m_lvl),
        .out_o  (m_out)
    );

    // legacy: bit clock counts master clock periods; standard: module clocks
    assign b_adv = legacy_map ? m_tick : 1'b1;

    aud_div_core #(.CNT_W(RATIO_W)) u_bdiv (
        .clk    (clk),
        .rst    (rst),
        .adv    (b_adv),
        .req    (b_sel),
        .tick_o (b_tick),
        .stb_o  (bclk_stb),
        .lvl_o  (b_lvl),
        .out_o  (bclk_out)
    );

    always_ff @(posedge clk) begin
        if (rst) bad_q <= 1'b0;
        else     bad_q <= !m_sel.valid || !b_sel.valid;
    end

    assign code_bad = bad_q;
    assign mclk_out = mclk_oe & m_out;

    // ---------------- assertions ----------------
    logic live_q;
    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b0;
        else     live_q <= 1'b1;
    end

    assert_legacy_parent_R5: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(legacy_map) && bclk_stb) |-> m_stb)
        else $error("legacy bit clock started off a master clock boundary");

    assert_oe_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (!mclk_oe && !m_lvl) |-> !mclk_out)
        else $error("master clock visible while disabled");

endmodule

// File: tb/aud_clk_div_tb.sv
module aud_clk_div_tb;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] mclk_code = 4'd5;
    logic [3:0] bclk_code = 4'd3;
    logic       mclk_oe = 1'b1;
    logic       legacy_map = 1'b0;
    logic       mclk_out, bclk_out, bclk_stb, code_bad;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    aud_clk_div u_dut (
        .clk        (clk),
        .rst        (rst),
        .mclk_code  (mclk_code),
        .bclk_code  (bclk_code),
        .mclk_oe    (mclk_oe),
        .legacy_map (legacy_map),
        .mclk_out   (mclk_out),
        .bclk_out   (bclk_out),
        .bclk_stb   (bclk_stb),
        .code_bad   (code_bad)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int std_ratio(input int c);
        int k;
        if (c == 14) return 176;
        if (c == 15) return 192;
        if (c <= 2) return c;
        k = c - 3;
        return ((k % 2) == 0) ? (4 << (k / 2)) : (6 << (k / 2));
    endfunction

    function automatic int leg_m_ratio(input int c);
        return std_ratio(c + 1);
    endfunction

    function automatic int leg_b_ratio(input int c);
        return std_ratio(c + 2);
    endfunction

    // skips two rising edges, then measures one full period
    task automatic measure(input bit use_b, output int per, output int hi, output int stbs);
        bit prev, cur;
        int rises;
        rises = 0; per = 0; hi = 0; stbs = 0;
        @(negedge clk);
        prev = use_b ? bclk_out : mclk_out;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            cur = use_b ? bclk_out : mclk_out;
            if (cur && !prev) rises++;
            if (rises == 3) break;
            if (rises == 2) begin
                per++;
                hi += int'(cur);
                stbs += int'(bclk_stb);
            end
            prev = cur;
        end
        if (rises < 3) per = -1;
    endtask

    task automatic check_bypass(input bit use_b, input string req);
        repeat (4) begin
            @(posedge clk); #(CLK_P/4);
            check((use_b ? bclk_out : mclk_out) == 1'b1, req, int'(use_b ? bclk_out : mclk_out), 1);
            @(negedge clk); #1;
            check((use_b ? bclk_out : mclk_out) == 1'b0, req, int'(use_b ? bclk_out : mclk_out), 0);
        end
    endtask

    task automatic check_low(input bit use_b, input int n, input string req);
        int highs;
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            highs += int'(use_b ? bclk_out : mclk_out);
        end
        check(highs == 0, req, highs, 0);
    endtask

    initial begin
        #(CLK_P * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int per, hi, stbs, exp;

        // R11: reset state
        repeat (4) begin
            @(negedge clk);
            check({mclk_out, bclk_out, bclk_stb, code_bad} == 4'b0, "R11",
                  int'({mclk_out, bclk_out, bclk_stb, code_bad}), 0);
        end
        @(negedge clk);
        rst = 1'b0;

        // R1, R6: standard master clock sweep
        for (int c = 2; c < 16; c++) begin
            mclk_code = 4'(c);
            exp = std_ratio(c);
            measure(1'b0, per, hi, stbs);
            check(per == exp, "R1 mclk period", per, exp);
            check(hi == exp / 2, "R6 mclk high time", hi, exp / 2);
        end
        mclk_code = 4'd1;
        repeat (400) @(negedge clk);
        check_bypass(1'b0, "R7 mclk bypass");

        // R2, R6, R10: standard bit clock sweep, master code varied alongside
        for (int c = 2; c < 16; c++) begin
            bclk_code = 4'(c);
            mclk_code = 4'(((c * 7) % 15) + 1);
            exp = std_ratio(c);
            measure(1'b1, per, hi, stbs);
            check(per == exp, "R2 bclk period", per, exp);
            check(hi == exp / 2, "R6 bclk high time", hi, exp / 2);
            check(stbs == 1, "R10 strobe count", stbs, 1);
        end
        bclk_code = 4'd1;
        repeat (400) @(negedge clk);
        check_bypass(1'b1, "R7 bclk bypass");

        // R8: change ratio 8 -> 4 right after a rising edge
        begin
            bit prev, cur;
            int n, h;
            mclk_code = 4'd5;
            bclk_code = 4'd5;
            measure(1'b0, per, hi, stbs);
            @(negedge clk); prev = mclk_out;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk); cur = mclk_out;
                if (cur && !prev) break;
                prev = cur;
            end
            mclk_code = 4'd3;
            n = 1; h = 1;
            prev = 1'b1;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk); cur = mclk_out;
                if (cur && !prev) break;
                n++; h += int'(cur);
                prev = cur;
            end
            check(n == 8, "R8 old period completes", n, 8);
            check(h == 4, "R8 old high time", h, 4);
            measure(1'b0, per, hi, stbs);
            check(per == 4, "R8 new period", per, 4);
        end

        // R9: output enable
        mclk_oe = 1'b0;
        check_low(1'b0, 300, "R9 mclk gated");
        measure(1'b1, per, hi, stbs);
        check(per == 8, "R9 bclk keeps running", per, 8);
        mclk_oe = 1'b1;

        // R3: illegal code 0
        mclk_code = 4'd0;
        @(negedge clk);
        check(code_bad == 1'b1, "R3 flag on mclk code 0", int'(code_bad), 1);
        repeat (20) @(negedge clk);
        check_low(1'b0, 400, "R3 mclk held low");
        mclk_code = 4'd5;
        bclk_code = 4'd0;
        @(negedge clk);
        check(code_bad == 1'b1, "R3 flag on bclk code 0", int'(code_bad), 1);
        repeat (20) @(negedge clk);
        check_low(1'b1, 400, "R3 bclk held low");
        bclk_code = 4'd5;
        @(negedge clk);
        check(code_bad == 1'b0, "R3 flag clears", int'(code_bad), 0);
        measure(1'b0, per, hi, stbs);
        check(per == 8, "R3 mclk resumes", per, 8);

        // R4: legacy master clock map
        legacy_map = 1'b1;
        bclk_code = 4'd0;
        for (int c = 1; c < 8; c++) begin
            mclk_code = 4'(c);
            exp = leg_m_ratio(c);
            measure(1'b0, per, hi, stbs);
            check(per == exp, "R4 legacy mclk period", per, exp);
            check(hi == exp / 2, "R6 legacy mclk high time", hi, exp / 2);
        end
        mclk_code = 4'd0;
        repeat (100) @(negedge clk);
        check_bypass(1'b0, "R4 legacy code 0 bypass");
        check(code_bad == 1'b0, "R4 legacy code 0 legal", int'(code_bad), 0);
        mclk_code = 4'd9;
        @(negedge clk);
        check(code_bad == 1'b1, "R4 legacy code 9 illegal", int'(code_bad), 1);
        repeat (40) @(negedge clk);
        check_low(1'b0, 100, "R4 legacy mclk held low");

        // R5: legacy bit clock = master ratio x bit ratio
        for (int m = 0; m < 8; m++) begin
            for (int b = 0; b < 6; b++) begin
                mclk_code = 4'(m);
                bclk_code = 4'(b);
                exp = leg_m_ratio(m) * leg_b_ratio(b);
                measure(1'b1, per, hi, stbs);
                check(per == exp, "R5 legacy bclk period", per, exp);
                check(hi == exp / 2, "R6 legacy bclk high time", hi, exp / 2);
                check(stbs == 1, "R10 legacy strobe count", stbs, 1);
            end
        end
        mclk_code = 4'd1;
        bclk_code = 4'd11;
        @(negedge clk);
        check(code_bad == 1'b0, "R5 bit 3 ignored flag", int'(code_bad), 0);
        measure(1'b1, per, hi, stbs);
        check(per == 16, "R5 bit 3 ignored period", per, 16);
        bclk_code = 4'd6;
        @(negedge clk);
        check(code_bad == 1'b1, "R5 legacy bclk code 6 illegal", int'(code_bad), 1);
        repeat (40) @(negedge clk);
        check_low(1'b1, 100, "R5 legacy bclk held low");
        bclk_code = 4'd7;
        @(negedge clk);
        check(code_bad == 1'b1, "R5 legacy bclk code 7 illegal", int'(code_bad), 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule